// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This unit decides whether one local interrupt controller takes an inter-processor interrupt message. Every controller in the system sees the same message and evaluates it against its own identity: its physical ID, its logical ID register and its logical format setting. Each controller then raises or withholds its own accept flag. Delivery-mode handling, priority arbitration and the message fabric live elsewhere.

Two addressing generations are supported. In the legacy (xAPIC) mode IDs are 8 bits wide. A logical destination is read either as a flat bitmask or as a cluster number plus a member mask. In the extended (x2APIC) mode the full 32-bit ID is compared, and the broadcast value is all ones across the whole field. A two-bit shorthand field can override the destination entirely.

A request is presented with `req_valid`. The verdict appears on `accept` one clock later, qualified by `acc_valid`.

Top module: `dest_match_unit`

## Requirements
- R1: After reset `acc_valid` and `accept` are 0. `acc_valid` follows `req_valid` one clock later. `accept` is 0 whenever `acc_valid` is 0.
- R2: Legacy logical, flat format (`cluster_fmt`=0): the unit accepts when `dest_field[7:0]` and `ldr_val[31:24]` share at least one set bit. Destination bits naming no one have no effect.
- R3: Legacy logical, cluster format (`cluster_fmt`=1): the unit accepts when `dest_field[7:4]` equals `ldr_val[31:28]` and `dest_field[3:0]` shares a set bit with `ldr_val[27:24]`.
- R4: Legacy logical destination `dest_field[7:0]`=0xFF is accepted in both formats, whatever the logical ID.
- R5: Legacy physical: the unit accepts when `dest_field[7:0]` equals `my_id[7:0]`. The upper bits of both are ignored, so units with aliased low IDs all accept.
- R6: Physical broadcast: in legacy mode `dest_field[7:0]`=0xFF is accepted. In extended mode only 0xFFFFFFFF is broadcast, and 0x000000FF is an ordinary ID.
- R7: Extended physical: all 32 bits of `dest_field` are compared with `my_id`.
- R8: Extended logical: the unit accepts when `dest_field[31:16]` equals `ldr_val[31:16]` and `dest_field[15:0]` shares a set bit with `ldr_val[15:0]`. The destination 0xFFFFFFFF is accepted by all units.
- R9: Shorthand 2'b10 (everyone including the sender) accepts regardless of the destination, its mode and the IDs. Shorthand 2'b00 means use the destination.
- R10: Shorthand 2'b01 (self) accepts exactly when `sender_is_me` is 1.
- R11: Shorthand 2'b11 (everyone but the sender) accepts exactly when `sender_is_me` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A message is presented this cycle |
| dest_field | input | 32 | Destination field of the message |
| dest_logical | input | 1 | 1 = logical destination, 0 = physical |
| shorthand | input | 2 | 00 none, 01 self, 10 all including sender, 11 all but sender |
| ext_mode | input | 1 | 1 = extended (x2APIC) addressing, 0 = legacy |
| sender_is_me | input | 1 | This unit is the sender of the message |
| my_id | input | 32 | This unit's physical ID |
| ldr_val | input | 32 | Logical destination register value |
| cluster_fmt | input | 1 | Legacy logical format: 1 = cluster, 0 = flat |
| acc_valid | output | 1 | Verdict valid, one cycle after `req_valid` |
| accept | output | 1 | This unit takes the message |

## Verification
The flat format is swept exhaustively. Each single-bit logical ID is tried against every destination that contains its bit, and against destinations that miss it. This separates overlap matching from equality matching and shows that stray bits for absent targets do not matter. The cluster patterns pair matching and non-matching cluster numbers with overlapping and disjoint member masks, so a check of only one half is exposed. Physical IDs that share low bits but differ in the upper bits separate legacy truncation from full extended comparison. The value 0xFF is applied in both modes to tell the two broadcast rules apart. Every shorthand is driven with both values of `sender_is_me` and with destinations that would otherwise miss.

// File: rtl/dm_pkg.sv
package dm_pkg;

   typedef enum logic [1:0] {
      SH_NONE    = 2'b00,
      SH_SELF    = 2'b01,
      SH_ALL_INC = 2'b10,
      SH_ALL_EXC = 2'b11
   } dm_short_e;

endpackage

// File: rtl/dm_phys_match.sv
module dm_phys_match #(
   parameter int ID_W  = 32,
   parameter int LEG_W = 8
) (
   input  logic            ext_mode,
   input  logic [ID_W-1:0] dest,
   input  logic [ID_W-1:0] my_id,
   output logic            hit
);
   localparam logic [LEG_W-1:0] LEG_BCAST = {LEG_W{1'b1}};
   localparam logic [ID_W-1:0]  EXT_BCAST = {ID_W{1'b1}};

   logic leg_hit, ext_hit;

   generate
      if (LEG_W > ID_W) begin : g_bad_width
         $error("dm_phys_match: LEG_W must not exceed ID_W");
      end
   endgenerate

   // legacy: only the low LEG_W bits take part, aliases all match
   always_comb begin
      leg_hit = (dest[LEG_W-1:0] == my_id[LEG_W-1:0]) ||
                (dest[LEG_W-1:0] == LEG_BCAST);
      ext_hit = (dest == my_id) || (dest == EXT_BCAST);
      hit     = ext_mode ? ext_hit : leg_hit;
   end
endmodule

// File: rtl/dm_logical_match.sv
module dm_logical_match #(
   parameter int ID_W  = 32,
   parameter int LEG_W = 8,
   parameter int CL_W  = 4
) (
   input  logic            ext_mode,
   input  logic            cluster_fmt,
   input  logic [ID_W-1:0] dest,
   input  logic [ID_W-1:0] ldr_val,
   output logic            hit
);
   localparam int MEM_W = LEG_W - CL_W;
   localparam int XH_W  = ID_W / 2;

   logic [LEG_W-1:0] lid, dl;
   logic             leg_bcast, flat_hit, clu_hit, ext_bcast, ext_hit;

   generate
      if (CL_W >= LEG_W || CL_W < 1) begin : g_bad_cluster
         $error("dm_logical_match: CL_W must be in 1..LEG_W-1");
      end
      if ((ID_W % 2) != 0) begin : g_bad_id
         $error("dm_logical_match: ID_W must be even");
      end
      if (LEG_W > ID_W) begin : g_bad_leg
         $error("dm_logical_match: LEG_W must not exceed ID_W");
      end
   endgenerate

   always_comb begin
      lid       = ldr_val[ID_W-1 -: LEG_W];
      dl        = dest[LEG_W-1:0];
      leg_bcast = &dl;
      flat_hit  = |(dl & lid);
      clu_hit   = (dl[LEG_W-1 -: CL_W] == lid[LEG_W-1 -: CL_W]) &&
                  (|(dl[MEM_W-1:0] & lid[MEM_W-1:0]));
      ext_bcast = &dest;
      ext_hit   = (dest[ID_W-1 -: XH_W] == ldr_val[ID_W-1 -: XH_W]) &&
                  (|(dest[XH_W-1:0] & ldr_val[XH_W-1:0]));
      if (ext_mode)
         hit = ext_bcast || ext_hit;
      else
         hit = leg_bcast || (cluster_fmt ? clu_hit : flat_hit);
   end
endmodule

// File: rtl/dm_short_sel.sv
module dm_short_sel
   import dm_pkg::*;
(
   input  logic [1:0] shorthand,
   input  logic       addr_hit,
   input  logic       sender_is_me,
   output logic       take
);
   dm_short_e sh;

   always_comb begin
      sh = dm_short_e'(shorthand);
      unique case (sh)
         SH_NONE:    take = addr_hit;
         SH_SELF:    take = sender_is_me;
         SH_ALL_INC: take = 1'b1;
         SH_ALL_EXC: take = !sender_is_me;
         default:    take = 1'b0;
      endcase
   end
endmodule

// File: rtl/dest_match_unit.sv
module dest_match_unit #(
   parameter int ID_W  = 32,
   parameter int LEG_W = 8,
   parameter int CL_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [ID_W-1:0] dest_field,
   input  logic            dest_logical,
   input  logic [1:0]      shorthand,
   input  logic            ext_mode,
   input  logic            sender_is_me,
   input  logic [ID_W-1:0] my_id,
   input  logic [ID_W-1:0] ldr_val,
   input  logic            cluster_fmt,
   output logic            acc_valid,
   output logic            accept
);
   logic phys_hit, log_hit, addr_hit, take;

   dm_phys_match #(.ID_W(ID_W), .LEG_W(LEG_W)) u_phys (
      .ext_mode (ext_mode),
      .dest     (dest_field),
      .my_id    (my_id),
      .hit      (phys_hit)
   );

   dm_logical_match #(.ID_W(ID_W), .LEG_W(LEG_W), .CL_W(CL_W)) u_log (
      .ext_mode    (ext_mode),
      .cluster_fmt (cluster_fmt),
      .dest        (dest_field),
      .ldr_val     (ldr_val),
      .hit         (log_hit)
   );

   assign addr_hit = dest_logical ? log_hit : phys_hit;

   dm_short_sel u_sh (
      .shorthand    (shorthand),
      .addr_hit     (addr_hit),
      .sender_is_me (sender_is_me),
      .take         (take)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         accept    <= 1'b0;
      end else begin
         acc_valid <= req_valid;
         accept    <= req_valid && take;
      end
   end

   // R1: the verdict is never asserted without its valid
   p_acc_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !accept);

   // R1: valid tracks the request one cycle later
   p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> acc_valid);

   // R9: everyone-including-self always accepted
   p_all_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && shorthand == 2'b10) |=> accept);

   // R10: self shorthand follows the sender flag
   p_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && shorthand == 2'b01) |=> (accept == $past(sender_is_me)));

   // R11: sender never accepts its own all-but-self message
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && shorthand == 2'b11 && sender_is_me) |=> !accept);

   // R4: legacy logical broadcast
   p_log_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && shorthand == 2'b00 && dest_logical && !ext_mode &&
       dest_field[LEG_W-1:0] == {LEG_W{1'b1}}) |=> accept);

   // R6: extended physical broadcast
   p_ext_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && shorthand == 2'b00 && !dest_logical && ext_mode &&
       dest_field == {ID_W{1'b1}}) |=> accept);
endmodule

// File: tb/sim_dest_match_unit.sv
module sim_dest_match_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] dest_field = '0;
   logic        dest_logical = 1'b0;
   logic [1:0]  shorthand = 2'b00;
   logic        ext_mode = 1'b0;
   logic        sender_is_me = 1'b0;
   logic [31:0] my_id = '0;
   logic [31:0] ldr_val = '0;
   logic        cluster_fmt = 1'b0;
   logic        acc_valid, accept;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic  exp;
      string tag;
   } sb_item_t;
   sb_item_t sbq[$];

   always #10 clk = ~clk;   // 50 MHz

   dest_match_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .dest_field(dest_field), .dest_logical(dest_logical),
      .shorthand(shorthand), .ext_mode(ext_mode),
      .sender_is_me(sender_is_me), .my_id(my_id), .ldr_val(ldr_val),
      .cluster_fmt(cluster_fmt), .acc_valid(acc_valid), .accept(accept)
   );

   task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // independent reference, written per requirement
   function automatic logic model(input logic [31:0] d, input logic lg,
                                  input logic [1:0] sh, input logic ex,
                                  input logic me, input logic [31:0] pid,
                                  input logic [31:0] ldr, input logic cf);
      logic r;
      if (sh == 2'b10) return 1'b1;              // R9
      if (sh == 2'b01) return me;                // R10
      if (sh == 2'b11) return !me;               // R11
      if (!lg) begin
         if (ex) return (d == 32'hFFFF_FFFF) || (d == pid);         // R6 R7
         return (d[7:0] == 8'hFF) || (d[7:0] == pid[7:0]);          // R5 R6
      end
      if (ex) begin                                                 // R8
         if (d == 32'hFFFF_FFFF) return 1'b1;
         r = 1'b0;
         for (int b = 0; b < 16; b++) if (d[b] && ldr[b]) r = 1'b1;
         return r && (d[31:16] == ldr[31:16]);
      end
      if (d[7:0] == 8'hFF) return 1'b1;                             // R4
      r = 1'b0;
      if (!cf) begin                                                // R2
         for (int b = 0; b < 8; b++) if (d[b] && ldr[24+b]) r = 1'b1;
         return r;
      end
      for (int b = 0; b < 4; b++) if (d[b] && ldr[24+b]) r = 1'b1;  // R3
      return r && (d[7:4] == ldr[31:28]);
   endfunction

   task automatic drive(input logic [31:0] d, input logic lg, input logic [1:0] sh,
                        input logic ex, input logic me, input logic [31:0] pid,
                        input logic [31:0] ldr, input logic cf, input string tag);
      sb_item_t it;
      @(negedge clk);
      req_valid = 1'b1; dest_field = d; dest_logical = lg; shorthand = sh;
      ext_mode = ex; sender_is_me = me; my_id = pid; ldr_val = ldr; cluster_fmt = cf;
      it.exp = model(d, lg, sh, ex, me, pid, ldr, cf);
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: verdict registered one clock after the request
   always @(posedge clk) begin
      #5;
      if (rst_n && acc_valid) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R1 unexpected verdict", accept, 1'b0);
         end else begin
            sb_item_t it;
            it = sbq.pop_front();
            chk(accept === it.exp, it.tag, accept, it.exp);
         end
      end
   end

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      chk(acc_valid === 1'b0, "R1 reset valid", acc_valid, 1'b0);
      chk(accept === 1'b0, "R1 reset accept", accept, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R1: idle request with an accepting shorthand yields nothing
      shorthand = 2'b10; req_valid = 1'b0;
      @(posedge clk); #5;
      chk(acc_valid === 1'b0, "R1 idle valid", acc_valid, 1'b0);
      chk(accept === 1'b0, "R1 idle accept", accept, 1'b0);

      // R2: flat sweep, single-bit logical IDs, every other bit pattern
      for (int i = 0; i < 8; i++)
         for (int k = 0; k < 255; k++) begin
            logic [7:0] lid = 8'(1 << i);
            logic [7:0] dd  = 8'(k) | lid;
            drive({24'h0, dd}, 1'b1, 2'b00, 1'b0, 1'b0, 32'h5, {lid, 24'h0}, 1'b0, "R2 flat hit");
            if ((8'(k) & lid) == 0 && 8'(k) != 8'hFF && k != 0)
               drive({24'h0, 8'(k)}, 1'b1, 2'b00, 1'b0, 1'b0, 32'h5, {lid, 24'h0}, 1'b0, "R2 flat miss");
         end

      // R3: cluster matches and misses
      drive(32'h35, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h3400_0000, 1'b1, "R3 cluster hit");
      drive(32'h25, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h3400_0000, 1'b1, "R3 cluster wrong number");
      drive(32'h3A, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h3400_0000, 1'b1, "R3 cluster disjoint members");
      drive(32'hEE, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'hE200_0000, 1'b1, "R3 cluster E hit");
      drive(32'h35, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h3400_0000, 1'b0, "R3 same value flat");
      for (int c = 0; c < 15; c++)
         for (int m = 1; m < 16; m++)
            drive({24'h0, 4'(c), 4'(m)}, 1'b1, 2'b00, 1'b0, 1'b0, 0,
                  {4'(c), 4'h2, 24'h0}, 1'b1, "R3 cluster sweep");

      // R4: logical broadcast in both formats
      drive(32'hFF, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h0, 1'b0, "R4 flat broadcast");
      drive(32'hFF, 1'b1, 2'b00, 1'b0, 1'b0, 0, 32'h1200_0000, 1'b1, "R4 cluster broadcast");

      // R5: legacy physical, aliasing on low bits
      drive(32'h07, 1'b0, 2'b00, 1'b0, 1'b0, 32'h0000_0007, 0, 0, "R5 phys hit");
      drive(32'h07, 1'b0, 2'b00, 1'b0, 1'b0, 32'h0000_0107, 0, 0, "R5 phys alias");
      drive(32'hAB00_0007, 1'b0, 2'b00, 1'b0, 1'b0, 32'h7, 0, 0, "R5 phys upper ignored");
      drive(32'h08, 1'b0, 2'b00, 1'b0, 1'b0, 32'h7, 0, 0, "R5 phys miss");

      // R6: broadcast values per mode
      drive(32'hFF, 1'b0, 2'b00, 1'b0, 1'b0, 32'h3, 0, 0, "R6 legacy broadcast");
      drive(32'hFF, 1'b0, 2'b00, 1'b1, 1'b0, 32'h3, 0, 0, "R6 0xFF not ext broadcast");
      drive(32'hFFFF_FFFF, 1'b0, 2'b00, 1'b1, 1'b0, 32'h3, 0, 0, "R6 ext broadcast");

      // R7: extended physical full compare
      drive(32'h0001_0007, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0001_0007, 0, 0, "R7 ext hit");
      drive(32'h0000_0007, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0001_0007, 0, 0, "R7 ext alias rejected");
      drive(32'h0000_00FF, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0000_00FF, 0, 0, "R7 ext id 0xFF");

      // R8: extended logical
      drive(32'h0002_0010, 1'b1, 2'b00, 1'b1, 1'b0, 0, 32'h0002_0030, 0, "R8 ext logical hit");
      drive(32'h0003_0010, 1'b1, 2'b00, 1'b1, 1'b0, 0, 32'h0002_0030, 0, "R8 ext cluster miss");
      drive(32'h0002_0001, 1'b1, 2'b00, 1'b1, 1'b0, 0, 32'h0002_0030, 0, "R8 ext member miss");
      drive(32'h0000_00FF, 1'b1, 2'b00, 1'b1, 1'b0, 0, 32'h0002_0030, 1'b0, "R8 legacy bcast not ext");
      drive(32'hFFFF_FFFF, 1'b1, 2'b00, 1'b1, 1'b0, 0, 32'h0002_0030, 0, "R8 ext logical broadcast");

      // R9..R11: shorthands against missing destinations
      for (int me = 0; me < 2; me++) begin
         drive(32'h12, 1'b0, 2'b10, 1'b0, 1'(me), 32'h3, 0, 0, "R9 all incl");
         drive(32'h12, 1'b1, 2'b10, 1'b1, 1'(me), 32'h3, 0, 0, "R9 all incl ext");
         drive(32'h12, 1'b0, 2'b01, 1'b0, 1'(me), 32'h3, 0, 0, "R10 self");
         drive(32'h03, 1'b0, 2'b01, 1'b0, 1'(me), 32'h3, 0, 0, "R10 self ignores dest");
         drive(32'h12, 1'b0, 2'b11, 1'b0, 1'(me), 32'h3, 0, 0, "R11 all excl");
         drive(32'h03, 1'b0, 2'b11, 1'b1, 1'(me), 32'h3, 0, 0, "R11 all excl ignores dest");
      end
      drive(32'h03, 1'b0, 2'b00, 1'b0, 1'b1, 32'h3, 0, 0, "R9 none uses dest");

      @(negedge clk); req_valid = 1'b0;
      repeat (3) @(posedge clk);
      #6;
      chk(sbq.size() == 0, "R1 all verdicts seen", sbq.size() == 0, 1'b1);
      chk(acc_valid === 1'b0, "R1 valid drops", acc_valid, 1'b0);
      summary();
      $finish;
   end
endmodule